// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

This block is a watchdog timer clocked from a slow oscillator that runs apart from the main system clock. A binary divider counts oscillator cycles. A four-bit period select picks one of ten timeout lengths, each twice the one before it. If software does not kick the watchdog before the chosen length runs out, the block raises a one-cycle reset request and starts the count again.

A small control register holds three fields: the run enable, a change-enable flag and the period select. A static safety-level input, standing in for a non-volatile fuse, decides which fields need a two-step unlock. The first step is one write with both change-enable and enable at one. The second step is one write with change-enable at zero, and it must land within a fixed number of clocks after the first. In the relaxed level, software may start the watchdog or change its period freely, but stopping it needs the unlock. In the strict level, the watchdog always runs, and only the period select is guarded.

Top module: `wdog_timed_lock`

## Requirements
- R1: After reset the register reads back with change-enable at 0 and period select at 0. Enable reads 0 in the relaxed level (safety_hi=0) and 1 in the strict level (safety_hi=1). The read/write layout is bit 0 enable, bit 1 change-enable, bits 5:2 period select.
- R2: In the relaxed level, a plain write with bit 0 at 1 starts the watchdog. No unlock is needed.
- R3: In the relaxed level, a write that clears enable while the unlock window is closed leaves the watchdog running.
- R4: In the relaxed level, every write updates the period select, whether or not the window is open.
- R5: In the strict level, enable always reads 1, and the enable value in a committing write has no effect.
- R6: In the strict level, the period select changes only through a committing write. Plain writes leave it unchanged.
- R7: An unlock is a single write with bits 1 and 0 both at 1. It opens the window, and bit 1 then reads 1. A write with bit 1 at 1 and bit 0 at 0 opens nothing.
- R8: A write with bit 1 at 0 commits when it is sampled on one of the 4 clock edges after the unlock write. A commit closes the window. If no commit arrives by then, bit 1 clears itself, and later commit attempts have no effect.
- R9: With the watchdog running and no kick, wdt_rst goes high exactly 2^(BASE_LOG2+k) clock cycles after the kick edge, where k is the period select. The pulse lasts one cycle, and the count then starts again.
- R10: Period select codes 10 to 15 give the same timeout as code 9.
- R11: A kick clears the count, so kicks closer together than the timeout prevent any reset request. A stopped watchdog never requests a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| safety_hi | input | 1 | Static safety level: 0 relaxed, 1 strict |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 6 | Write data: {period select, change-enable, enable} |
| rd_data | output | 6 | Register read-back in the same layout |
| kick | input | 1 | Clears the timeout count |
| wdt_rst | output | 1 | One-cycle reset request on timeout |

## Verification
Some properties are checked on every cycle. The reset request is never wider than one cycle, and it never follows a kick or a stopped watchdog. In the relaxed level, the enable cannot drop while the window is closed. In the strict level, the period select cannot move without an open window, and enable always reads one. Other behaviour needs the bench's scenarios. The exact timeout length for each period code is one such case, including the reserved codes. Another is the window's edge: a commit on the fourth clock is accepted and one on the fifth is rejected. The random write streams in both levels are compared cycle by cycle against a register model in the bench.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
// Shared types for the watchdog: the layout of the control register.
// Assumes a four-bit period select. Enable sits in the lowest bit.
package wdog_pkg;
    localparam int PSEL_W = 4;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;   // period select
        logic              chg;    // change-enable (unlock flag)
        logic              en;     // run enable
    } wdog_ctrl_t;

    localparam int CTRL_W = $bits(wdog_ctrl_t);
endpackage

// File: rtl/wdog_cfg.sv
`timescale 1ns/1ps
// Control register with a timed two-step unlock.
// Assumes safety_hi stays static after reset. Accepts at most one write per cycle.
// A commit is honoured on any of the UNLOCK_WIN edges that follow the unlock write.
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter int UNLOCK_WIN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       safety_hi,
    input  logic       wr_en,
    input  wdog_ctrl_t wr_ctrl,
    output logic       en_eff,
    output wdog_ctrl_t rd_ctrl
);
    localparam int WIN_W = (UNLOCK_WIN > 1) ? $clog2(UNLOCK_WIN) : 1;

    logic              en_q;
    logic              chg_q;
    logic [PSEL_W-1:0] psel_q;
    logic [WIN_W-1:0]  win_q;
    logic              commit;
    logic              unlock;
    logic              win_last;

    // Decode the kind of write presented this cycle
    always_comb begin
        commit   = wr_en & chg_q & ~wr_ctrl.chg;
        unlock   = wr_en & wr_ctrl.chg & wr_ctrl.en;
        win_last = (win_q == WIN_W'(UNLOCK_WIN - 1));
    end

    // Open, age and close the unlock window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_q <= 1'b0;
            win_q <= '0;
        end else if (commit) begin
            chg_q <= 1'b0;
        end else if (unlock) begin
            chg_q <= 1'b1;
            win_q <= '0;
        end else if (chg_q) begin
            if (win_last) chg_q <= 1'b0;
            else          win_q <= win_q + WIN_W'(1);
        end
    end

    // Relaxed-level enable: set freely, cleared only by a commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (!safety_hi) begin
            if (commit)                   en_q <= wr_ctrl.en;
            else if (wr_en && wr_ctrl.en) en_q <= 1'b1;
        end
    end

    // Period select: free in the relaxed level, commit-only in the strict level
    always_ff @(posedge clk) begin
        if (!rst_n)                     psel_q <= '0;
        else if (commit)                psel_q <= wr_ctrl.psel;
        else if (wr_en && !safety_hi)   psel_q <= wr_ctrl.psel;
    end

    // Effective enable and read-back
    always_comb begin
        en_eff       = en_q | safety_hi;
        rd_ctrl.psel = psel_q;
        rd_ctrl.chg  = chg_q;
        rd_ctrl.en   = en_eff;
    end

    AST_LVL1_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!safety_hi && en_eff && !chg_q) |=> en_eff);                        // R3
    AST_LVL2_PSEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (safety_hi && !chg_q) |=> $stable(psel_q));                          // R6
    AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctrl.chg && wr_ctrl.en) |=> rd_ctrl.chg);               // R7
endmodule

// File: rtl/wdog_div.sv
`timescale 1ns/1ps
// Timeout divider: counts clock cycles and fires on the selected tap.
// Tap t expires after 2^(BASE_LOG2+t) cycles. Codes beyond the last tap use the last tap.
// Assumes BASE_LOG2 >= 1, so a request is never wider than one cycle.
module wdog_div
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int NUM_TAPS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              kick,
    input  logic [PSEL_W-1:0] psel,
    output logic              wdt_rst
);
    localparam int CNT_W = BASE_LOG2 + NUM_TAPS - 1;
    localparam int TAP_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;

    logic [CNT_W-1:0] limit [NUM_TAPS];
    logic [CNT_W-1:0] cnt_q;
    logic [TAP_W-1:0] tap;
    logic             hit;

    // One terminal count per divider tap
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign limit[t] = CNT_W'((64'd1 << (BASE_LOG2 + t)) - 64'd1);
    end

    // Map the period select onto a tap, with reserved codes clamped to the longest
    always_comb begin
        if (int'(psel) >= NUM_TAPS) tap = TAP_W'(NUM_TAPS - 1);
        else                        tap = TAP_W'(psel);
        hit = en & ~kick & (cnt_q >= limit[tap]);
    end

    // Count cycles, restart on kick, stop or expiry, and register the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            wdt_rst <= 1'b0;
        end else begin
            wdt_rst <= hit;
            if (kick || !en || hit) cnt_q <= '0;
            else                    cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);                                               // R9
    AST_KICK_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !wdt_rst);                                                  // R11
    AST_OFF_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !wdt_rst);                                                   // R11
endmodule

// File: rtl/wdog_timed_lock.sv
`timescale 1ns/1ps
// Watchdog top: a locked control register feeding the timeout divider.
// Assumes clk is the slow watchdog oscillator and safety_hi is static.
module wdog_timed_lock #(
    parameter int BASE_LOG2  = 11,
    parameter int NUM_TAPS   = 10,
    parameter int UNLOCK_WIN = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        safety_hi,
    input  logic                        wr_en,
    input  logic [wdog_pkg::CTRL_W-1:0] wr_data,
    output logic [wdog_pkg::CTRL_W-1:0] rd_data,
    input  logic                        kick,
    output logic                        wdt_rst
);
    import wdog_pkg::*;

    wdog_ctrl_t wr_ctrl;
    wdog_ctrl_t rd_ctrl;
    logic       en_eff;

    // Reinterpret the bus words as register fields
    always_comb begin
        wr_ctrl = wdog_ctrl_t'(wr_data);
        rd_data = CTRL_W'(rd_ctrl);
    end

    wdog_cfg #(.UNLOCK_WIN(UNLOCK_WIN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .safety_hi (safety_hi),
        .wr_en     (wr_en),
        .wr_ctrl   (wr_ctrl),
        .en_eff    (en_eff),
        .rd_ctrl   (rd_ctrl)
    );

    wdog_div #(.BASE_LOG2(BASE_LOG2), .NUM_TAPS(NUM_TAPS)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_eff),
        .kick    (kick),
        .psel    (rd_ctrl.psel),
        .wdt_rst (wdt_rst)
    );

    AST_LVL2_READS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        safety_hi |-> rd_data[0]);                                           // R5
endmodule

// File: tb/sim_wdog_timed_lock.sv
`timescale 1ns/1ps
module sim_wdog_timed_lock;
    localparam int BL = 3;

    logic       clk = 1'b0;
    logic       rst_n, safety_hi, wr_en, kick;
    logic [5:0] wr_data;
    logic [5:0] rd_data;
    logic       wdt_rst;

    int n_chk = 0;
    int n_fail = 0;

    bit       lvl2;
    bit       m_en, m_chg;
    bit [3:0] m_psel;
    int       m_win;

    always #5 clk = ~clk;

    wdog_timed_lock #(.BASE_LOG2(BL), .NUM_TAPS(10), .UNLOCK_WIN(4)) u0 (
        .clk(clk), .rst_n(rst_n), .safety_hi(safety_hi), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .kick(kick), .wdt_rst(wdt_rst)
    );

    function automatic logic [5:0] mk(int psel, bit chg, bit en);
        return {psel[3:0], chg, en};
    endfunction

    function automatic int exp_rd();
        return int'({m_psel, m_chg, m_en | lvl2});
    endfunction

    function automatic int period(int code);
        int k = (code > 9) ? 9 : code;
        return 1 << (BL + k);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_apply(bit w, logic [5:0] d);
        bit commit = w && m_chg && !d[1];
        bit unlock = w && d[1] && d[0];
        if (commit) begin
            if (!lvl2) m_en = d[0];
            m_psel = d[5:2];
            m_chg = 0;
        end else begin
            if (unlock) begin m_chg = 1; m_win = 0; end
            else if (m_chg) begin
                if (m_win == 3) m_chg = 0; else m_win++;
            end
            if (w && !lvl2) begin m_en = m_en | d[0]; m_psel = d[5:2]; end
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, compare after
    task automatic cyc(bit w, logic [5:0] d, bit k, string req);
        wr_en = w; wr_data = d; kick = k;
        @(posedge clk);
        model_apply(w, d);
        @(negedge clk);
        wr_en = 0; kick = 0;
        chk(req, int'(rd_data), exp_rd());
    endtask

    task automatic do_reset(bit l2);
        lvl2 = l2; safety_hi = l2; rst_n = 0; wr_en = 0; kick = 0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_en = 0; m_chg = 0; m_psel = 0; m_win = 0;
        chk("R1", int'(rd_data), l2 ? 1 : 0);
    endtask

    // Kick, then find the first request and its width
    task automatic measure(int exp_p, string req);
        int first = -1;
        int width = 0;
        cyc(0, 6'd0, 1, "R11");
        for (int n = 1; n <= exp_p + 2; n++) begin
            @(negedge clk);
            if (wdt_rst) begin
                width++;
                if (first < 0) first = n;
            end
        end
        chk(req, first, exp_p);
        chk("R9", width, 1);
    endtask

    initial begin
        #(10 * 150000);
        n_fail++; n_chk++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        // relaxed level
        do_reset(0);
        cyc(1, mk(2, 0, 1), 0, "R2");
        chk("R2", int'(rd_data[0]), 1);
        cyc(1, mk(3, 0, 0), 0, "R3");
        chk("R3", int'(rd_data[0]), 1);
        chk("R4", int'(rd_data[5:2]), 3);
        cyc(1, mk(3, 1, 1), 0, "R7");
        chk("R7", int'(rd_data[1]), 1);
        repeat (3) cyc(0, 6'd0, 0, "R8");
        cyc(1, mk(5, 0, 0), 0, "R8");
        chk("R8", int'(rd_data), int'(mk(5, 0, 0)));
        cyc(1, mk(5, 0, 1), 0, "R2");
        cyc(1, mk(5, 1, 1), 0, "R7");
        repeat (4) cyc(0, 6'd0, 0, "R8");
        chk("R8", int'(rd_data[1]), 0);
        cyc(1, mk(6, 0, 0), 0, "R8");
        chk("R8", int'(rd_data[0]), 1);
        cyc(1, mk(6, 1, 0), 0, "R7");
        chk("R7", int'(rd_data[1]), 0);
        // timeouts per code, including reserved codes
        cyc(1, mk(0, 0, 1), 0, "R4");  measure(period(0), "R9");
        cyc(1, mk(2, 0, 1), 0, "R4");  measure(period(2), "R9");
        cyc(1, mk(9, 0, 1), 0, "R4");  measure(period(9), "R9");
        cyc(1, mk(12, 0, 1), 0, "R10"); measure(period(12), "R10");
        cyc(1, mk(15, 0, 1), 0, "R10"); measure(period(15), "R10");
        // regular kicks hold off the request
        cyc(1, mk(0, 0, 1), 0, "R4");
        for (int i = 0; i < 10; i++) begin
            cyc(0, 6'd0, 1, "R11");
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                chk("R11", int'(wdt_rst), 0);
            end
        end
        // stopped watchdog is silent
        do_reset(0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R11", int'(wdt_rst), 0);
        end
        // random stream, relaxed level
        for (int i = 0; i < 300; i++) begin
            logic [5:0] d = 6'($urandom);
            if ($urandom % 4 == 0) d[1:0] = 2'b11;
            cyc(bit'($urandom % 2), d, 0, "R4");
        end
        // strict level
        do_reset(1);
        cyc(1, mk(4, 0, 0), 0, "R6");
        chk("R6", int'(rd_data[5:2]), 0);
        cyc(1, mk(0, 1, 1), 0, "R7");
        cyc(1, mk(4, 0, 0), 0, "R5");
        chk("R5", int'(rd_data), int'(mk(4, 0, 1)));
        measure(period(4), "R9");
        for (int i = 0; i < 300; i++) begin
            logic [5:0] d = 6'($urandom);
            if ($urandom % 4 == 0) d[1:0] = 2'b11;
            cyc(bit'($urandom % 2), d, 0, "R6");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule